// File: doc/BRIEF.md
# Processor-Priority Bus Master Control with DMA Preemption

This block requests the bus on behalf of a device that arbitrates on a processor-priority request line. A device pulses `req_i` to post a request. The block raises `br_o` and watches the daisy-chained grant. If no request is pending, it passes the grant straight downstream. If a request is pending, it takes the grant, acknowledges it on `sack_o`, and takes bus ownership on `bbsy_o` once the previous owner lets go. It drops the acknowledge in the same cycle that it asserts ownership. The device ends its tenure with `done_i`.

The block also watches the bus DMA request line `npr_i`. When its grant arrives while a DMA request is pending and preemption is enabled, it refuses the grant and parks the acknowledge without taking the bus. It clears the park once the previous owner releases busy, so the processor serves the DMA device first. The local request stays posted, and the block arbitrates again on the next grant. Clearing `block_en_i`, or tying `npr_i` low when it is not wired, turns the block into a plain request/grant master control.

Bus-side inputs pass through a parameterised synchroniser before they reach the control state. The downstream grant path is combinational, so the daisy chain adds no clock latency.

Top module: `br_master_ctl`

## Requirements
- R1: During and after reset, with `bg_in_i` low, `br_o`, `sack_o`, `bbsy_o`, `master_o` and `bg_out_o` are all low.
- R2: A `req_i` pulse while idle raises `br_o` on the next clock. `br_o` stays high until a grant is accepted.
- R3: With no request posted, `bg_out_o` equals `bg_in_i` in the same cycle, whatever the level of `npr_i`. While a request is posted, acknowledged or owning the bus, `bg_out_o` is low.
- R4: A grant seen while `npr_i` is low (or while preemption is off) asserts `sack_o` and drops `br_o`. Inputs take SYNC_STAGES clocks to be seen.
- R5: After an accepted grant, once both the grant and the bus busy input `bbsy_i` are seen low, `bbsy_o` and `master_o` rise and `sack_o` falls in the same cycle.
- R6: A `done_i` pulse while owning the bus drops `bbsy_o` and `master_o` on the next clock and returns the block to idle.
- R7: A grant seen while `npr_i` is high (active high) and `block_en_i` is 1 asserts `sack_o`, keeps `br_o` high and never asserts `bbsy_o`.
- R8: A parked `sack_o` stays high for as long as `bbsy_i` is seen high. It clears once `bbsy_i` is seen low.
- R9: After a park clears, `br_o` stays high. The block waits for the grant to go low and then arbitrates again for the same request.
- R10: With `block_en_i` at 0, `npr_i` has no effect, and a grant is accepted as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| block_en_i | input | 1 | 1 enables DMA preemption of the grant |
| req_i | input | 1 | Device request pulse |
| done_i | input | 1 | Device finished its bus tenure |
| bg_in_i | input | 1 | Grant from upstream in the daisy chain |
| npr_i | input | 1 | Bus DMA request, active high; tie low if unwired |
| bbsy_i | input | 1 | Bus busy from other owners |
| br_o | output | 1 | Processor-priority bus request |
| bg_out_o | output | 1 | Grant passed downstream |
| sack_o | output | 1 | Selection acknowledge |
| bbsy_o | output | 1 | Bus busy driven as owner |
| master_o | output | 1 | Tells the device it owns the bus |

## Verification
The hardest situation to reach is a refused grant whose park must outlast a previous owner that holds busy for a varying time. The block must then re-arm and win a later grant for the same request. Each random scenario first sets busy high as if the processor owned the bus. It then picks DMA pending, preemption enable and the busy hold time from a fixed seed, and walks the grant through acceptance or refusal. Refused scenarios go on to withdraw the DMA request and issue a fresh grant. Directed cases force DMA pending with preemption disabled, and grants that arrive with no request posted.

// File: rtl/br_master_pkg.sv
package br_master_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_ACK    = 3'd2,
    ST_OWN    = 3'd3,
    ST_PARK   = 3'd4,
    ST_REARM  = 3'd5
  } br_state_e;
endpackage

// File: rtl/br_sync.sv
module br_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pipe_q <= '0;
        end else begin
          pipe_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
      end
      assign q_o = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/br_fsm.sv
module br_fsm
  import br_master_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      done_i,
  input  logic      bg_s_i,
  input  logic      bbsy_s_i,
  input  logic      npr_s_i,
  input  logic      block_en_i,
  output br_state_e state_o
);
  br_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_REQ;
      ST_REQ:   if (bg_s_i) state_d = (npr_s_i && block_en_i) ? ST_PARK : ST_ACK;
      ST_ACK:   if (!bg_s_i && !bbsy_s_i) state_d = ST_OWN;
      ST_OWN:   if (done_i) state_d = ST_IDLE;
      ST_PARK:  if (!bbsy_s_i) state_d = ST_REARM;
      // stale grant must clear before re-arbitrating
      ST_REARM: if (!bg_s_i) state_d = ST_REQ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/br_master_ctl.sv
module br_master_ctl
  import br_master_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic block_en_i,
  input  logic req_i,
  input  logic done_i,
  input  logic bg_in_i,
  input  logic npr_i,
  input  logic bbsy_i,
  output logic br_o,
  output logic bg_out_o,
  output logic sack_o,
  output logic bbsy_o,
  output logic master_o
);
  localparam int NUM_BUS_IN = 3;

  logic [NUM_BUS_IN-1:0] bus_raw, bus_s;
  logic bg_s, bbsy_s, npr_s;
  br_state_e state;

  assign bus_raw = {npr_i, bbsy_i, bg_in_i};

  br_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_BUS_IN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_raw),
    .q_o   (bus_s)
  );

  assign bg_s   = bus_s[0];
  assign bbsy_s = bus_s[1];
  assign npr_s  = bus_s[2];

  br_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .done_i    (done_i),
    .bg_s_i    (bg_s),
    .bbsy_s_i  (bbsy_s),
    .npr_s_i   (npr_s),
    .block_en_i(block_en_i),
    .state_o   (state)
  );

  assign br_o     = (state == ST_REQ) || (state == ST_PARK) || (state == ST_REARM);
  assign sack_o   = (state == ST_ACK) || (state == ST_PARK);
  assign bbsy_o   = (state == ST_OWN);
  assign master_o = (state == ST_OWN);
  // daisy chain stays combinational
  assign bg_out_o = bg_in_i && (state == ST_IDLE);
endmodule

// File: rtl/br_master_ctl_chk.sv
module br_master_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic br_o,
  input logic bg_out_o,
  input logic sack_o,
  input logic bbsy_o,
  input logic bbsy_s
);
  assert_no_pass_when_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_out_o |-> (!br_o && !sack_o && !bbsy_o));

  assert_br_drop_on_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(br_o) |-> (sack_o && !bbsy_o));

  assert_sack_off_when_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bbsy_o |-> !sack_o);

  assert_own_after_sack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bbsy_o) |-> $past(sack_o));

  assert_own_bus_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bbsy_o) |-> !$past(bbsy_s));

  assert_park_keeps_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sack_o) && !bbsy_o) |-> br_o);
endmodule

bind br_master_ctl br_master_ctl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .br_o    (br_o),
  .bg_out_o(bg_out_o),
  .sack_o  (sack_o),
  .bbsy_o  (bbsy_o),
  .bbsy_s  (bbsy_s)
);

// File: tb/br_master_ctl_tb_top.sv
module br_master_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int SETTLE     = SYNC + 2;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic block_en_i = 1'b0, req_i = 1'b0, done_i = 1'b0;
  logic bg_in_i = 1'b0, npr_i = 1'b0, bbsy_i = 1'b0;
  logic br_o, bg_out_o, sack_o, bbsy_o, master_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_master_ctl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .block_en_i(block_en_i), .req_i(req_i),
    .done_i(done_i), .bg_in_i(bg_in_i), .npr_i(npr_i), .bbsy_i(bbsy_i),
    .br_o(br_o), .bg_out_o(bg_out_o), .sack_o(sack_o), .bbsy_o(bbsy_o),
    .master_o(master_o)
  );

  function automatic logic exp_blocked(input logic npr, input logic en);
    return npr && en;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scenario(input logic npr, input logic en, input int hold);
    logic blk;
    blk = exp_blocked(npr, en);
    bbsy_i = 1'b1; npr_i = npr; block_en_i = en; bg_in_i = 1'b0;
    wait_cyc(SETTLE);
    // grant with nothing posted passes through (R3)
    bg_in_i = 1'b1; #1;
    chk("R3 idle pass", bg_out_o, 1'b1);
    bg_in_i = 1'b0; #1;
    chk("R3 idle pass low", bg_out_o, 1'b0);
    wait_cyc(1);
    req_i = 1'b1; wait_cyc(1); req_i = 1'b0;
    chk("R2 br raised", br_o, 1'b1);
    bg_in_i = 1'b1; #1;
    chk("R3 absorbed while posted", bg_out_o, 1'b0);
    wait_cyc(SETTLE);
    chk(blk ? "R7 sack on refuse" : "R4 sack on accept", sack_o, 1'b1);
    chk(blk ? "R7 br held" : (npr ? "R10 br dropped" : "R4 br dropped"), br_o, blk);
    chk("R7 no ownership yet", bbsy_o, 1'b0);
    bg_in_i = 1'b0;
    wait_cyc(hold);
    chk("R8 sack held while busy", sack_o, 1'b1);
    chk("R5 no own while busy", master_o, 1'b0);
    bbsy_i = 1'b0;
    wait_cyc(SETTLE);
    if (blk) begin
      chk("R8 park cleared", sack_o, 1'b0);
      chk("R9 request kept", br_o, 1'b1);
      chk("R7 never owned", bbsy_o, 1'b0);
      npr_i = 1'b0;
      bg_in_i = 1'b1;
      wait_cyc(SETTLE);
      chk("R9 rearbitrated sack", sack_o, 1'b1);
      chk("R9 rearbitrated br", br_o, 1'b0);
      bg_in_i = 1'b0;
      wait_cyc(SETTLE);
    end
    chk("R5 bbsy owned", bbsy_o, 1'b1);
    chk("R5 master", master_o, 1'b1);
    chk("R5 sack released", sack_o, 1'b0);
    bg_in_i = 1'b1; #1;
    chk("R3 no pass while owner", bg_out_o, 1'b0);
    bg_in_i = 1'b0;
    done_i = 1'b1; wait_cyc(1); done_i = 1'b0;
    chk("R6 bbsy released", bbsy_o, 1'b0);
    chk("R6 master released", master_o, 1'b0);
    chk("R6 idle br", br_o, 1'b0);
    wait_cyc(SETTLE);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    wait_cyc(3);
    chk("R1 br reset", br_o, 1'b0);
    chk("R1 sack reset", sack_o, 1'b0);
    chk("R1 bbsy reset", bbsy_o, 1'b0);
    chk("R1 master reset", master_o, 1'b0);
    chk("R1 pass reset", bg_out_o, 1'b0);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk("R1 br after reset", br_o, 1'b0);
    chk("R1 sack after reset", sack_o, 1'b0);
    // idle pass with DMA request pending (R3)
    npr_i = 1'b1; bg_in_i = 1'b1; #1;
    chk("R3 pass with npr", bg_out_o, 1'b1);
    bg_in_i = 1'b0; npr_i = 1'b0;
    wait_cyc(SETTLE);
    // directed corners
    scenario(1'b1, 1'b1, 0);   // R7 refuse, short hold
    scenario(1'b1, 1'b1, 12);  // R8 long hold
    scenario(1'b1, 1'b0, 3);   // R10 preemption off
    scenario(1'b0, 1'b1, 0);   // R4 plain accept
    for (int i = 0; i < 40; i++) begin
      scenario(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, 15)));
    end
    summary();
    $finish;
  end
endmodule